// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a serial peripheral (SPI) master that sends and receives a batch of bytes from a small on-chip queue without processor attention per byte. Each of the sixteen queue slots holds a byte to transmit, a command byte that steers the chip-select lines, and the byte received while that slot was shifted. Software fills the slots through a simple single-cycle register bus, programs a first-slot and a last-slot pointer, and raises a run bit. The engine then shifts the slots in order and signals completion through a status flag.

The serial port always runs in mode 3: clock polarity 1, clock phase 1, eight bits per slot, most significant bit first. The serial clock rate is set by a divisor. A per-slot continue bit decides whether chip select stays asserted into the following slot. A hold control keeps chip select asserted past the end of a run, so one long device transaction can be split across several queue runs. A programmable idle gap follows every byte.

Top module: `spiq_master`

## Requirements
- R1: After reset all chip-select outputs are high, the serial clock is high, the data output is 0, the run bit and the finished flag read 0, and every command slot reads 0x0F.
- R2: Register map on the 6-bit address: 0x00 divisor [7:0], 0x01 control (bit0 run, bit1 hold), 0x02 first-slot pointer [3:0], 0x03 last-slot pointer [3:0], 0x04 gap [7:0], 0x05 status (bit0 finished). Slot i transmit byte at 0x10+i, command byte at 0x20+i (bit7 continue, bits[3:0] select mask), received byte at 0x30+i. Written values read back unchanged.
- R3: The serial clock idles high. Each slot shifts 8 bits MSB first: the data output changes on the falling clock edge, the data input is sampled on the rising edge, and the 8 sampled bits are stored in that slot's received byte.
- R4: Each serial clock half period lasts exactly D system clocks, D being the divisor, and a divisor of 0 acts as 1.
- R5: A run processes slots from the first-slot pointer through the last-slot pointer inclusive, wrapping from slot 15 to slot 0.
- R6: While a slot shifts, the chip-select outputs equal that slot's select mask (a 0 bit selects that device).
- R7: A slot with the continue bit set keeps chip select asserted into the next slot. With it clear, all selects go high for one half period before the next slot begins.
- R8: When the last slot finishes, the run bit clears and the finished flag sets in the same cycle. Writing the status register with bit0 = 0 clears the flag.
- R9: After the last slot of a run, chip select keeps the last slot's mask when hold is set, and goes all high when hold is clear.
- R10: The time from the last rising clock edge of a slot to the first falling edge of the next is gap + 1 + 2·D system clocks, plus D more when the slot's continue bit is clear.
- R11: While the run bit is set, bus writes to slots, divisor, pointers, gap and control are ignored. The received-byte region is never writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low device selects |

## Verification
Pointer wrap from slot 15 back to 0 is driven directly: a design that counted upward without wrapping would run away and never finish, and one that stopped early would leave the later slots' received bytes stale. Gap timing between slots is measured against the formula with and without a deselect half period, and with the largest gap of 128. An off-by-one in the gap counter or a missing deselect shows up as a wrong cycle count. Writes aimed at a slot and at the divisor in the middle of a run must not reach the wire or the readback. The hold control is checked at run end: a design that releases select too early raises one extra deassertion, and one that holds it wrongly shows the last mask on the pins.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    localparam int SLOTS  = 16;
    localparam int PW     = $clog2(SLOTS);
    localparam int DW     = 8;
    localparam int NCS    = 4;
    localparam int AW     = 6;
    localparam int BITS_PER_SLOT = 8;
    localparam int HALVES = 2 * BITS_PER_SLOT;
    localparam int HW     = $clog2(HALVES);

    // region select on address bits [5:4]
    localparam logic [1:0] RG_CTRL = 2'b00;
    localparam logic [1:0] RG_TX   = 2'b01;
    localparam logic [1:0] RG_CMD  = 2'b10;
    localparam logic [1:0] RG_RX   = 2'b11;

    // offsets inside the control region
    localparam logic [3:0] OF_DIV  = 4'h0;
    localparam logic [3:0] OF_CTL  = 4'h1;
    localparam logic [3:0] OF_SPTR = 4'h2;
    localparam logic [3:0] OF_EPTR = 4'h3;
    localparam logic [3:0] OF_GAP  = 4'h4;
    localparam logic [3:0] OF_STAT = 4'h5;

    localparam logic [DW-1:0] CMD_RESET = DW'((1 << NCS) - 1);

    typedef struct packed {
        logic           cont;
        logic [NCS-1:0] sel_n;
    } slot_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_DESEL
    } eng_state_t;

    function automatic slot_cmd_t decode_cmd(input logic [DW-1:0] w);
        slot_cmd_t c;
        c.cont  = w[DW-1];
        c.sel_n = w[NCS-1:0];
        return c;
    endfunction

    function automatic logic [DW-1:0] eff_div(input logic [DW-1:0] d);
        return (d == '0) ? DW'(1) : d;
    endfunction
endpackage

// File: rtl/spiq_regs.sv
module spiq_regs
    import spiq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [PW-1:0] slot_idx,
    output logic [DW-1:0] slot_tx,
    output logic [DW-1:0] slot_cmd,
    input  logic          rx_we,
    input  logic [DW-1:0] rx_data,
    input  logic          run_end,
    output logic          start,
    output logic          busy,
    output logic          done,
    output logic          hold_sel,
    output logic [DW-1:0] div,
    output logic [DW-1:0] gap,
    output logic [PW-1:0] sptr,
    output logic [PW-1:0] eptr
);
    logic [DW-1:0] tx_mem  [SLOTS];
    logic [DW-1:0] cmd_mem [SLOTS];
    logic [DW-1:0] rx_mem  [SLOTS];

    logic [1:0] region;
    logic [3:0] ofs;
    logic       cfg_wr;

    assign region = addr[AW-1:AW-2];
    assign ofs    = addr[3:0];
    assign cfg_wr = wr_en && !busy;
    assign start  = cfg_wr && region == RG_CTRL && ofs == OF_CTL && wdata[0];

    assign slot_tx  = tx_mem[slot_idx];
    assign slot_cmd = cmd_mem[slot_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                tx_mem[i]  <= '0;
                cmd_mem[i] <= CMD_RESET;
                rx_mem[i]  <= '0;
            end
            div      <= '0;
            gap      <= '0;
            sptr     <= '0;
            eptr     <= '0;
            hold_sel <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            if (cfg_wr) begin
                case (region)
                    RG_TX:  tx_mem[ofs[PW-1:0]]  <= wdata;
                    RG_CMD: cmd_mem[ofs[PW-1:0]] <= wdata;
                    RG_CTRL: begin
                        case (ofs)
                            OF_DIV:  div      <= wdata;
                            OF_GAP:  gap      <= wdata;
                            OF_SPTR: sptr     <= wdata[PW-1:0];
                            OF_EPTR: eptr     <= wdata[PW-1:0];
                            OF_CTL:  hold_sel <= wdata[1];
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
            if (start)
                busy <= 1'b1;
            else if (run_end)
                busy <= 1'b0;
            if (run_end)
                done <= 1'b1;
            else if (wr_en && region == RG_CTRL && ofs == OF_STAT && !wdata[0])
                done <= 1'b0;
            if (rx_we)
                rx_mem[slot_idx] <= rx_data;
        end
    end

    always_comb begin
        rdata = '0;
        case (region)
            RG_TX:  rdata = tx_mem[ofs[PW-1:0]];
            RG_CMD: rdata = cmd_mem[ofs[PW-1:0]];
            RG_RX:  rdata = rx_mem[ofs[PW-1:0]];
            default: begin
                case (ofs)
                    OF_DIV:  rdata = div;
                    OF_GAP:  rdata = gap;
                    OF_SPTR: rdata = DW'(sptr);
                    OF_EPTR: rdata = DW'(eptr);
                    OF_CTL:  rdata = {{(DW-2){1'b0}}, hold_sel, busy};
                    OF_STAT: rdata = {{(DW-1){1'b0}}, done};
                    default: rdata = '0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/spiq_clkgen.sv
module spiq_clkgen
    import spiq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] lim;

    assign lim  = eff_div(div) - DW'(1);
    assign tick = !clr && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + DW'(1);
    end
endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
    import spiq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [PW-1:0]  sptr,
    input  logic [PW-1:0]  eptr,
    input  logic [DW-1:0]  gap,
    input  logic           hold_sel,
    input  logic           tick,
    input  logic [DW-1:0]  slot_tx,
    input  logic [DW-1:0]  slot_cmd,
    input  logic           miso,
    output logic [PW-1:0]  slot_idx,
    output logic           tick_clr,
    output logic           rx_we,
    output logic [DW-1:0]  rx_data,
    output logic           run_end,
    output logic           sck,
    output logic           mosi,
    output logic [NCS-1:0] cs_n
);
    eng_state_t    state;
    logic [DW-1:0] shreg;
    logic [HW-1:0] half;
    logic [DW-1:0] dcnt;
    slot_cmd_t     cmd;
    logic          slot_last;

    assign cmd       = decode_cmd(slot_cmd);
    assign slot_last = (slot_idx == eptr);
    assign tick_clr  = (state == ST_IDLE) || (state == ST_GAP);
    assign rx_we     = (state == ST_GAP) && (dcnt == gap);
    assign rx_data   = shreg;
    assign run_end   = rx_we && slot_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            slot_idx <= '0;
            shreg    <= '0;
            half     <= '0;
            dcnt     <= '0;
            sck      <= 1'b1;
            mosi     <= 1'b0;
            cs_n     <= '1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        slot_idx <= sptr;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cs_n  <= cmd.sel_n;
                    shreg <= slot_tx;
                    half  <= '0;
                    if (tick)
                        state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!half[0]) begin
                            sck  <= 1'b0;
                            mosi <= shreg[DW-1];
                        end else begin
                            sck   <= 1'b1;
                            shreg <= {shreg[DW-2:0], miso};
                        end
                        half <= half + HW'(1);
                        if (half == HW'(HALVES - 1)) begin
                            state <= ST_GAP;
                            dcnt  <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    if (dcnt == gap) begin
                        if (slot_last) begin
                            if (!hold_sel)
                                cs_n <= '1;
                            state <= ST_IDLE;
                        end else begin
                            slot_idx <= slot_idx + PW'(1);
                            if (cmd.cont) begin
                                state <= ST_LOAD;
                            end else begin
                                cs_n  <= '1;
                                state <= ST_DESEL;
                            end
                        end
                    end else begin
                        dcnt <= dcnt + DW'(1);
                    end
                end
                ST_DESEL: begin
                    if (tick)
                        state <= ST_LOAD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           spi_sck,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    logic [PW-1:0] slot_idx;
    logic [DW-1:0] slot_tx;
    logic [DW-1:0] slot_cmd;
    logic          rx_we;
    logic [DW-1:0] rx_data;
    logic          run_end;
    logic          start;
    logic          run_busy;
    logic          done_flag;
    logic          hold_sel;
    logic [DW-1:0] div_q;
    logic [DW-1:0] gap_q;
    logic [PW-1:0] sptr;
    logic [PW-1:0] eptr;
    logic          tick;
    logic          tick_clr;

    spiq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .slot_idx (slot_idx),
        .slot_tx  (slot_tx),
        .slot_cmd (slot_cmd),
        .rx_we    (rx_we),
        .rx_data  (rx_data),
        .run_end  (run_end),
        .start    (start),
        .busy     (run_busy),
        .done     (done_flag),
        .hold_sel (hold_sel),
        .div      (div_q),
        .gap      (gap_q),
        .sptr     (sptr),
        .eptr     (eptr)
    );

    spiq_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .div  (div_q),
        .tick (tick)
    );

    spiq_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sptr     (sptr),
        .eptr     (eptr),
        .gap      (gap_q),
        .hold_sel (hold_sel),
        .tick     (tick),
        .slot_tx  (slot_tx),
        .slot_cmd (slot_cmd),
        .miso     (spi_miso),
        .slot_idx (slot_idx),
        .tick_clr (tick_clr),
        .rx_we    (rx_we),
        .rx_data  (rx_data),
        .run_end  (run_end),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n)
    );
endmodule

// File: rtl/spiq_checker.sv
module spiq_checker
    import spiq_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           sck,
    input logic [NCS-1:0] cs_n,
    input logic           busy,
    input logic           done,
    input logic [DW-1:0]  div
);
    // R3: clock rests high whenever no run is in progress
    a_r3_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck);

    // R6: a low serial clock only ever occurs with some device selected
    a_r6_cs_under_sck_low: assert property (@(posedge clk) disable iff (rst)
        !sck |-> (cs_n != '1));

    // R6: selects do not move while the clock stays low
    a_r6_cs_steady_low: assert property (@(posedge clk) disable iff (rst)
        (!sck && $past(!sck)) |-> $stable(cs_n));

    // R8: the run bit falls only together with the finished flag set
    a_r8_end_sets_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R11: divisor is frozen during a run
    a_r11_div_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(div));
endmodule

bind spiq_master spiq_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .sck  (spi_sck),
    .cs_n (spi_cs_n),
    .busy (run_busy),
    .done (done_flag),
    .div  (div_q)
);

// File: tb/tb_spiq_master.sv
module tb_spiq_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck;
    logic       spi_mosi;
    logic       spi_miso;
    logic [3:0] spi_cs_n;

    always #2 clk = ~clk;

    spiq_master dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc = cyc + 1;

    // device model and monitor
    bit         mon_on = 0;
    int         bitn = 0;
    int         desel_cnt = 0;
    logic [7:0] sl_tx  [16];
    logic [7:0] got_mo [16];
    logic [3:0] got_cs [16];
    int         fall_t [128];
    int         rise_t [128];
    wire        all_hi = &spi_cs_n;

    always @(negedge spi_sck) begin
        if (mon_on && bitn < 128) begin
            spi_miso = sl_tx[bitn / 8][7 - (bitn % 8)];
            fall_t[bitn] = cyc;
        end
    end

    always @(posedge spi_sck) begin
        if (mon_on && bitn < 128) begin
            got_mo[bitn / 8] = {got_mo[bitn / 8][6:0], spi_mosi};
            got_cs[bitn / 8] = spi_cs_n;
            rise_t[bitn] = cyc;
            bitn = bitn + 1;
        end
    end

    always @(posedge all_hi) begin
        if (mon_on) desel_cnt = desel_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int effd(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic run_q(input int sp, input int ep, input int dv, input int gp,
                         input bit caq, input bit poke);
        int n;
        int ed;
        int slot;
        int exp_desel;
        int waited;
        logic [7:0] e_tx  [16];
        logic [7:0] e_cmd [16];
        logic [7:0] v;
        logic [3:0] m;
        n  = ((ep - sp + 16) % 16) + 1;
        ed = effd(dv);
        for (int k = 0; k < n; k++) begin
            slot = (sp + k) % 16;
            e_tx[k] = 8'($urandom);
            m = 4'($urandom);
            if (m == 4'hF) m = 4'hE;
            e_cmd[k] = {1'($urandom), 3'b000, m};
            sl_tx[k] = 8'($urandom);
            wr(6'(8'h10 + slot), e_tx[k]);
            wr(6'(8'h20 + slot), e_cmd[k]);
        end
        wr(6'h00, 8'(dv));
        wr(6'h04, 8'(gp));
        wr(6'h02, 8'(sp));
        wr(6'h03, 8'(ep));
        rd(6'h00, v); chk("R2 divisor readback", v, dv);
        rd(6'h04, v); chk("R2 gap readback", v, gp);
        rd(6'(8'h20 + sp), v); chk("R2 command readback", v, e_cmd[0]);
        rd(6'(8'h10 + sp), v); chk("R2 transmit readback", v, e_tx[0]);
        bitn = 0; desel_cnt = 0; mon_on = 1;
        wr(6'h01, {6'b0, caq, 1'b1});
        if (poke) begin
            wr(6'(8'h10 + sp), ~e_tx[0]);
            wr(6'h00, 8'(dv + 3));
            wr(6'h02, 8'(sp + 1));
        end
        waited = 0;
        v = 8'h00;
        while (!v[0] && waited < 40000) begin
            @(negedge clk);
            rd(6'h05, v);
            waited++;
        end
        chk("R8 run finished in time", int'(waited < 40000), 1);
        mon_on = 0;
        rd(6'h01, v); chk("R8 run bit cleared", v, {6'b0, caq, 1'b0});
        chk("R5 bit count equals slots in run", bitn, 8 * n);
        for (int k = 0; k < n; k++) begin
            slot = (sp + k) % 16;
            chk("R3 MOSI byte msb first", got_mo[k], e_tx[k]);
            chk("R6 select mask during slot", got_cs[k], e_cmd[k][3:0]);
            rd(6'(8'h30 + slot), v);
            chk("R3 received byte stored", v, sl_tx[k]);
        end
        chk("R4 full period", fall_t[1] - fall_t[0], 2 * ed);
        chk("R4 half period", rise_t[0] - fall_t[0], ed);
        if (n > 1)
            chk("R10 inter-slot timing", fall_t[8] - rise_t[7],
                gp + 1 + 2 * ed + (e_cmd[0][7] ? 0 : ed));
        exp_desel = caq ? 0 : 1;
        for (int k = 0; k < n - 1; k++)
            if (!e_cmd[k][7]) exp_desel++;
        chk("R7 deselect count", desel_cnt, exp_desel);
        chk("R9 select after run", spi_cs_n, caq ? e_cmd[n-1][3:0] : 4'hF);
        if (poke) begin
            rd(6'(8'h10 + sp), v); chk("R11 slot write ignored while running", v, e_tx[0]);
            rd(6'h00, v); chk("R11 divisor write ignored while running", v, dv);
            rd(6'h02, v); chk("R11 pointer write ignored while running", v, sp);
            wr(6'(8'h30 + sp), ~sl_tx[0]);
            rd(6'(8'h30 + sp), v); chk("R11 received byte not writable", v, sl_tx[0]);
        end
        wr(6'h05, 8'h01);
        rd(6'h05, v); chk("R8 writing one keeps flag", v, 1);
        wr(6'h05, 8'h00);
        rd(6'h05, v); chk("R8 flag cleared by zero", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        spi_miso = 1'b0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 selects high", spi_cs_n, 4'hF);
        chk("R1 clock high", spi_sck, 1);
        chk("R1 data out low", spi_mosi, 0);
        rd(6'h01, v); chk("R1 control zero", v, 0);
        rd(6'h05, v); chk("R1 status zero", v, 0);
        rd(6'h27, v); chk("R1 command slot default", v, 8'h0F);

        // directed corners
        run_q(0, 0, 1, 0, 0, 0);      // single slot, fastest clock
        run_q(3, 7, 0, 2, 0, 0);      // divisor zero acts as one
        run_q(14, 1, 3, 5, 1, 0);     // wrap 14,15,0,1 with hold
        run_q(2, 2, 2, 0, 0, 0);      // start after held run
        run_q(0, 15, 2, 128, 0, 0);   // full queue, large gap
        run_q(5, 9, 4, 3, 1, 1);      // writes during run ignored
        run_q(9, 9, 1, 0, 1, 0);      // single slot held

        // random runs
        for (int r = 0; r < 12; r++) begin
            run_q(int'($urandom % 16), int'($urandom % 16), int'($urandom % 5),
                  int'($urandom % 12), 1'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule